// File: doc/BRIEF.md
# Cascadable Configuration Memory Streamer

This block is the readout side of a configuration store that feeds a stored bitstream to a device being configured. A byte-wide memory array holds the image. A side load port fills that array while the block is deselected. Once the block is selected and released from hold, an address counter steps on every rising edge of the configuration clock. The current location appears either as one bit on lane 0 (serial mode) or as a full byte on eight lanes (parallel mode).

When the counter moves past the last valid address, the block stops driving and pulls its cascade output low. That output drives the select input of the next block in a chain, so a bitstream longer than one array continues on the shared data lines with no gap. Drive is given as a data vector plus a per-lane enable vector. A lane whose enable is low is treated as high-impedance.

Top module: `cfg_stream_mem`

## Requirements
- R1: The address counter increments on a rising clock edge only while `sel_n` is 0 and `hold_n` is 1. The outputs show the new location right after that edge, so the receiver samples it on the following edge.
- R2: While `hold_n` is 0, the counter is cleared at each clock edge and every bit of `q_en` is 0.
- R3: While `sel_n` is 1 (standby), the counter is cleared at each clock edge and every bit of `q_en` is 0.
- R4: `next_sel_n` is 0 only while `sel_n` is 0, `hold_n` is 1, and the counter is above the terminal count. Otherwise it is 1.
- R5: `next_sel_n` returns to 1 within the same cycle, with no clock edge needed, when `hold_n` falls or `sel_n` rises.
- R6: In serial mode (`par_mode` = 0) only lane 0 is enabled (`q_en` = 8'h01). Bit address n reads byte n/8 and sends bit 7-(n mod 8) of that byte, so the most significant bit goes first.
- R7: In parallel mode (`par_mode` = 1) all lanes are enabled (`q_en` = 8'hFF). Address n puts byte n on `q`, with bit k on lane k.
- R8: The terminal count is 8*DEPTH_BYTES-1 in serial mode and DEPTH_BYTES-1 in parallel mode. Above it, the counter no longer advances and `q_en` is 8'h00.
- R9: A load through `load_en` writes the array only while `sel_n` is 1. A load attempted while `sel_n` is 0 leaves the stored byte unchanged.
- R10: When two blocks are chained (`next_sel_n` of the first drives `sel_n` of the second), the stream of the second starts on the very cycle after the last unit of the first. Exactly one block drives each lane used by the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| sel_n | input | 1 | Active-low select; high puts the block in standby |
| hold_n | input | 1 | Active-low hold: clears the counter and disables drive |
| par_mode | input | 1 | 0 = serial on lane 0, 1 = byte on eight lanes |
| load_en | input | 1 | Load strobe for the memory array |
| load_addr | input | AW | Byte address for a load |
| load_byte | input | 8 | Byte to store |
| q | output | 8 | Data lanes |
| q_en | output | 8 | Per-lane drive enable (0 = high-impedance) |
| next_sel_n | output | 1 | Cascade select for the next block in the chain |

## Verification
The hardest situation to reach is the hand-off between two chained blocks. The first block must cross its terminal count while the second, held in standby until that cycle, takes over the shared lanes on the next unit. The bench wires two instances through the cascade output, loads distinct images into both, and walks the whole combined stream in both modes. At every sample it checks the merged lane value and that exactly one instance drives. The bench also drops `hold_n` or raises `sel_n` between clock edges while the first block is past its terminal count, to show that the cascade output releases at once.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

   typedef enum logic {
      XFER_SERIAL   = 1'b0,
      XFER_PARALLEL = 1'b1
   } xfer_mode_e;

   localparam int unsigned LANES = 8;

   function automatic int unsigned cnt_width(input int unsigned depth_bytes);
      return $clog2(depth_bytes * LANES) + 1;
   endfunction

endpackage

// File: rtl/cfg_mem_array.sv
module cfg_mem_array #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          standby,
   input  logic          load_en,
   input  logic [AW-1:0] load_addr,
   input  logic [7:0]    load_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_byte
);

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (load_en && standby) begin
         store[load_addr] <= load_byte;
      end
   end

   assign rd_byte = store[rd_addr];

endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          run,
   input  logic [CW-1:0] tc,
   output logic [CW-1:0] cnt,
   output logic          past
);

   assign past = (cnt > tc);

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt <= '0;
      end else if (run && !past) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_STEP_WHEN_RUN: assert property (@(posedge clk) disable iff (clr)
      (run && !past) |=> (cnt == $past(cnt) + 1'b1)); // R1

   AST_FROZEN_PAST_TC: assert property (@(posedge clk) disable iff (clr)
      past |=> $stable(cnt)); // R8

endmodule

// File: rtl/cfg_out_drive.sv
module cfg_out_drive
   import cfg_stream_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  xfer_mode_e  mode,
   input  logic        active,
   input  logic [7:0]  byte_in,
   input  logic [2:0]  bit_sel,
   output logic [7:0]  q,
   output logic [7:0]  q_en
);

   logic serial_bit;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign serial_bit = byte_in[3'd7 - bit_sel];
      end else begin : g_lsb_first
         assign serial_bit = byte_in[bit_sel];
      end
   endgenerate

   assign q[0]    = (mode == XFER_PARALLEL) ? byte_in[0] : serial_bit;
   assign q_en[0] = active;

   generate
      for (genvar ln = 1; ln < LANES; ln++) begin : g_upper_lane
         assign q[ln]    = byte_in[ln];
         assign q_en[ln] = active && (mode == XFER_PARALLEL);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({mode, active, q_en})) begin
         AST_SERIAL_LANE0_ONLY: assert (mode == XFER_PARALLEL || q_en[7:1] == 7'd0); // R6
         AST_PARALLEL_ALL_LANES: assert (!(active && mode == XFER_PARALLEL) || q_en == 8'hFF); // R7
      end
   end

endmodule

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem
   import cfg_stream_pkg::*;
#(
   parameter int unsigned DEPTH_BYTES = 16,
   parameter bit          MSB_FIRST   = 1'b1,
   parameter int unsigned AW          = $clog2(DEPTH_BYTES)
) (
   input  logic          clk,
   input  logic          sel_n,
   input  logic          hold_n,
   input  logic          par_mode,
   input  logic          load_en,
   input  logic [AW-1:0] load_addr,
   input  logic [7:0]    load_byte,
   output logic [7:0]    q,
   output logic [7:0]    q_en,
   output logic          next_sel_n
);

   localparam int unsigned CW = cnt_width(DEPTH_BYTES);
   localparam logic [CW-1:0] TC_SERIAL   = CW'(DEPTH_BYTES * LANES - 1);
   localparam logic [CW-1:0] TC_PARALLEL = CW'(DEPTH_BYTES - 1);

   generate
      if (DEPTH_BYTES < 2) begin : g_chk_depth_min
         $error("cfg_stream_mem: DEPTH_BYTES must be at least 2");
      end
      if ((DEPTH_BYTES & (DEPTH_BYTES - 1)) != 0) begin : g_chk_depth_pow2
         $error("cfg_stream_mem: DEPTH_BYTES must be a power of two");
      end
      if (AW != $clog2(DEPTH_BYTES)) begin : g_chk_aw
         $error("cfg_stream_mem: AW must equal clog2(DEPTH_BYTES)");
      end
   endgenerate

   xfer_mode_e    mode;
   logic          enabled;
   logic          standby;
   logic [CW-1:0] tc;
   logic [CW-1:0] cnt;
   logic          past;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_byte;
   logic          active;

   assign mode    = xfer_mode_e'(par_mode);
   assign standby = sel_n;
   assign enabled = !sel_n && hold_n;
   assign tc      = (mode == XFER_PARALLEL) ? TC_PARALLEL : TC_SERIAL;
   assign rd_addr = (mode == XFER_PARALLEL) ? cnt[AW-1:0] : cnt[AW+2:3];
   assign active  = enabled && !past;

   cfg_addr_counter #(
      .CW (CW)
   ) u_counter (
      .clk  (clk),
      .clr  (!enabled),
      .run  (enabled),
      .tc   (tc),
      .cnt  (cnt),
      .past (past)
   );

   cfg_mem_array #(
      .DEPTH (DEPTH_BYTES),
      .AW    (AW)
   ) u_array (
      .clk       (clk),
      .standby   (standby),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_byte (load_byte),
      .rd_addr   (rd_addr),
      .rd_byte   (rd_byte)
   );

   cfg_out_drive #(
      .MSB_FIRST (MSB_FIRST)
   ) u_drive (
      .mode    (mode),
      .active  (active),
      .byte_in (rd_byte),
      .bit_sel (cnt[2:0]),
      .q       (q),
      .q_en    (q_en)
   );

   assign next_sel_n = !(enabled && past);

   always_comb begin
      if (!$isunknown({sel_n, hold_n, next_sel_n, q_en})) begin
         AST_CASCADE_RELEASE: assert (!(sel_n || !hold_n) || next_sel_n); // R5
         AST_DISABLED_NO_DRIVE: assert (!(sel_n || !hold_n) || q_en == 8'h00); // R2
         AST_HANDOFF_SILENT: assert (next_sel_n || q_en == 8'h00); // R10
      end
   end

   AST_CLEARED_IN_STANDBY: assert property (@(posedge clk) disable iff (!hold_n)
      sel_n |=> (cnt == '0)); // R3

   AST_CASCADE_ONLY_PAST: assert property (@(posedge clk) disable iff (!hold_n || sel_n)
      !next_sel_n |-> (cnt > tc)); // R4

endmodule

// File: tb/tb_cfg_stream_mem.sv
module tb_cfg_stream_mem;

   localparam int unsigned DEPTH = 4;
   localparam int unsigned AW    = 2;
   localparam int unsigned NVEC  = 12;

   // vector: {sel_n, hold_n, par_mode, exp_q_en[7:0], exp_q_masked[7:0], exp_next_sel_n}
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1},  // R3 standby
      {1'b0, 1'b1, 1'b1, 8'hFF, 8'h3C, 1'b1},  // R1 R7 addr 1
      {1'b0, 1'b1, 1'b1, 8'hFF, 8'hF0, 1'b1},  // R7 addr 2
      {1'b0, 1'b1, 1'b1, 8'hFF, 8'h81, 1'b1},  // R7 addr 3 = tc
      {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R8 R4 past tc
      {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R8 stays past
      {1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1},  // R2 hold
      {1'b0, 1'b1, 1'b0, 8'h01, 8'h00, 1'b1},  // R6 bit addr 1
      {1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 1'b1},  // R6 bit addr 2
      {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1},  // R3 standby clears
      {1'b0, 1'b1, 1'b1, 8'hFF, 8'h3C, 1'b1},  // R1 restart from 0
      {1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}   // R2 hold again
   };

   logic          clk = 1'b0;
   logic          sel_n_a = 1'b1;
   logic          hold_n = 1'b0;
   logic          par_mode = 1'b1;
   logic          load_en_a = 1'b0;
   logic          load_en_b = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [7:0]    load_byte = '0;
   logic [7:0]    q_a, q_en_a, q_b, q_en_b;
   logic          nsel_a, nsel_b;

   logic [7:0] img_a [DEPTH];
   logic [7:0] img_b [DEPTH];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cfg_stream_mem #(.DEPTH_BYTES(DEPTH)) dut (
      .clk        (clk),
      .sel_n      (sel_n_a),
      .hold_n     (hold_n),
      .par_mode   (par_mode),
      .load_en    (load_en_a),
      .load_addr  (load_addr),
      .load_byte  (load_byte),
      .q          (q_a),
      .q_en       (q_en_a),
      .next_sel_n (nsel_a)
   );

   cfg_stream_mem #(.DEPTH_BYTES(DEPTH)) dut_b (
      .clk        (clk),
      .sel_n      (nsel_a),
      .hold_n     (hold_n),
      .par_mode   (par_mode),
      .load_en    (load_en_b),
      .load_addr  (load_addr),
      .load_byte  (load_byte),
      .q          (q_b),
      .q_en       (q_en_b),
      .next_sel_n (nsel_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input bit to_b, input int unsigned addr, input logic [7:0] val);
      @(negedge clk);
      load_addr = AW'(addr);
      load_byte = val;
      load_en_a = !to_b;
      load_en_b = to_b;
      @(negedge clk);
      load_en_a = 1'b0;
      load_en_b = 1'b0;
   endtask

   task automatic run_chain(input bit par);
      int unsigned n_units;
      logic [7:0] mq;
      logic [7:0] ebyte;
      logic [7:0] act_q;
      @(negedge clk);
      hold_n = 1'b0;
      sel_n_a = 1'b1;
      par_mode = par;
      @(negedge clk);
      hold_n = 1'b1;
      sel_n_a = 1'b0;
      n_units = par ? 2 * DEPTH : 16 * DEPTH;
      for (int unsigned i = 0; i < n_units; i++) begin
         #1;
         if (par) begin
            ebyte = (i < DEPTH) ? img_a[i] : img_b[i - DEPTH];
            act_q = q_en_a[7] ? q_a : q_b;
            chk("R10 parallel chain byte", {23'd0, q_en_a[7] ^ q_en_b[7], act_q},
                {23'd0, 1'b1, ebyte});
         end else begin
            mq = ((i / 8) < DEPTH) ? img_a[i / 8] : img_b[(i / 8) - DEPTH];
            ebyte = {7'd0, mq[7 - (i % 8)]};
            act_q = {7'd0, (q_en_a[0] & q_a[0]) | (q_en_b[0] & q_b[0])};
            chk("R10 serial chain bit", {23'd0, q_en_a[0] ^ q_en_b[0], act_q},
                {23'd0, 1'b1, ebyte});
         end
         @(negedge clk);
      end
      #1;
      chk("R8 chain end all lanes off", {16'd0, q_en_a, q_en_b}, 32'd0);
      chk("R4 last block cascade low", {31'd0, nsel_b}, 32'd0);
   endtask

   initial begin
      img_a = '{8'hA5, 8'h3C, 8'hF0, 8'h81};
      img_b = '{8'h6E, 8'h17, 8'hC9, 8'h42};

      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R2 reset state q_en", {24'd0, q_en_a}, 32'd0);
      chk("R2 reset state cascade", {31'd0, nsel_a}, 32'd1);

      for (int unsigned k = 0; k < DEPTH; k++) begin
         load(1'b0, k, img_a[k]);
         load(1'b1, k, img_b[k]);
      end

      // vector table walk
      for (int v = 0; v < NVEC; v++) begin
         sel_n_a  = VEC[v][19];
         hold_n   = VEC[v][18];
         par_mode = VEC[v][17];
         @(negedge clk);
         chk($sformatf("R1-table v%0d q_en", v), {24'd0, q_en_a}, {24'd0, VEC[v][16:9]});
         chk($sformatf("R7 table v%0d data", v), {24'd0, q_a & q_en_a}, {24'd0, VEC[v][8:1]});
         chk($sformatf("R4 table v%0d cascade", v), {31'd0, nsel_a}, {31'd0, VEC[v][0]});
      end

      // R5: release on hold falling, between edges
      sel_n_a = 1'b0; hold_n = 1'b1; par_mode = 1'b1;
      repeat (DEPTH + 1) @(negedge clk);
      #1;
      chk("R4 past tc cascade low", {31'd0, nsel_a}, 32'd0);
      @(posedge clk);
      #2;
      hold_n = 1'b0;
      #1;
      chk("R5 cascade high on hold", {31'd0, nsel_a}, 32'd1);
      chk("R2 lanes off on hold", {24'd0, q_en_a}, 32'd0);

      // R5: release on select rising, between edges
      @(negedge clk);
      hold_n = 1'b1;
      repeat (DEPTH + 1) @(negedge clk);
      #1;
      chk("R8 parallel past tc lanes off", {24'd0, q_en_a}, 32'd0);
      @(posedge clk);
      #2;
      sel_n_a = 1'b1;
      #1;
      chk("R5 cascade high on standby", {31'd0, nsel_a}, 32'd1);

      // R9: load ignored while selected
      @(negedge clk);
      sel_n_a = 1'b0; hold_n = 1'b0;
      load_addr = 2'd2; load_byte = 8'h00; load_en_a = 1'b1;
      @(negedge clk);
      load_en_a = 1'b0;
      sel_n_a = 1'b1;
      @(negedge clk);
      hold_n = 1'b1; sel_n_a = 1'b0; par_mode = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R9 selected load ignored", {24'd0, q_a & q_en_a}, {24'd0, img_a[2]});
      @(negedge clk);
      sel_n_a = 1'b1;
      load(1'b0, 2, 8'h5A);
      img_a[2] = 8'h5A;
      @(negedge clk);
      sel_n_a = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R9 standby load applied", {24'd0, q_a & q_en_a}, {24'd0, img_a[2]});

      run_chain(1'b0);
      run_chain(1'b1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule